// File: doc/BRIEF.md
# Single-Wire Bus Slave Mode Controller

This block is the protocol sequencer on the slave side of a single-wire command bus in which every byte is followed by an acknowledge slot. The master drives its acknowledge (MAK) or no-acknowledge (NoMAK) first. The slave then answers with its own acknowledge. A bit-level front end decodes the bus. It hands this controller whole bytes, master acknowledge strobes, a missed-edge flag and a filtered copy of the line. The controller decides after each byte and each acknowledge whether the transfer goes on, ends cleanly in standby, or drops into idle. When a write command ends correctly, it starts the internal write cycle.

A transfer opens with a falling edge on the line while in standby. A fixed header byte follows and is closed by NoMAK. Then come the device address byte and a command byte, and after that optional address and data bytes, each closed by MAK or NoMAK. In idle the controller ignores everything until the line has been held high long enough to count as a standby pulse. A standby pulse returns the block to standby from any mode. Bytes arrive with a one-cycle valid strobe and are taken in the same cycle. There is no back-pressure, because every decision completes in one clock.

Top module: `swbus_slave_ctrl`

## Requirements
- R1: After reset, `mode` is 0 (standby), `sak_en` is 0 and `wr_start` is 0.
- R2: In standby, a high-to-low change of `bus_line` moves `mode` to 1 (header) on the next clock edge.
- R3: `bus_line` high for SBY_CYCLES consecutive clocks (default 16) is a standby pulse. It forces `mode` to 0 on the next edge from every mode.
- R4: In idle (`mode` 6), bytes, acknowledge strobes, missed edges and line falls have no effect until a standby pulse arrives.
- R5: In header mode, only byte HDR_BYTE (default 8'h55) followed by NoMAK leads to device-address mode (`mode` 2). Any other byte, or a MAK, leads to idle. `sak_en` stays 0 throughout header mode.
- R6: In device-address mode, a byte other than DEV_ADDR (default 8'hA0) leads to idle. A matching byte raises `sak_en` until the acknowledge, and a MAK then leads to command mode (`mode` 3).
- R7: `edge_missed` in modes 1 to 5 leads to idle on the next edge.
- R8: Opcode bytes are READ 8'h31, WRITE 8'h32, WREN 8'h41, WRDI 8'h42, RDSR 8'h51, WRSR 8'h52, SETALL 8'h61 and ERASEALL 8'h62. Any other command byte leads to idle. READ, WRITE, WRSR, SETALL or ERASEALL received while `wr_busy` is high also leads to idle.
- R9: A MAK after the command byte of WREN, WRDI, SETALL or ERASEALL leads to idle. A MAK after the WRSR data byte also leads to idle.
- R10: A NoMAK while `sak_en` is high ends the command and returns `mode` to 0.
- R11: `wr_start` pulses for one cycle on the NoMAK that closes WRITE data, WRSR data, SETALL or ERASEALL, provided the write-enable latch is set and `wr_busy` is low. A NoMAK after WREN sets the latch. A NoMAK after WRDI clears it, and so does every `wr_start`.
- R12: After READ and a MAK, `mode` is 4 (address). The address byte loads `mem_addr`, and a MAK moves to data mode (`mode` 5). Each further byte increments `mem_addr` by one, wrapping at 8 bits, and a MAK keeps data mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_line | input | 1 | Filtered bus line level |
| byte_valid | input | 1 | One-cycle strobe: `byte_data` holds a completed byte |
| byte_data | input | 8 | Decoded byte |
| mak_stb | input | 1 | Master acknowledge received |
| nomak_stb | input | 1 | Master no-acknowledge received |
| edge_missed | input | 1 | Timing recovery lost an expected edge |
| wr_busy | input | 1 | Internal write cycle in progress |
| mode | output | 3 | 0 standby, 1 header, 2 device address, 3 command, 4 address, 5 data, 6 idle |
| sak_en | output | 1 | Slave acknowledge enabled for the pending slot |
| wr_start | output | 1 | One-cycle internal write start |
| mem_addr | output | 8 | Current array address |

## Verification
A wrong internal state shows up first on `mode`, one clock after the byte or strobe that caused it. A lost write-enable latch or a wrong opcode class stays hidden until the closing NoMAK. At that point `wr_start` is missing or spurious in the same cycle that `mode` returns to standby. Read address faults show on `mem_addr` one edge after each data byte. Idle leakage is caught by driving traffic into idle and seeing `mode` leave 6 without a standby pulse.

// File: rtl/swbus_pkg.sv
package swbus_pkg;
  typedef enum logic [2:0] {
    M_STANDBY = 3'd0,
    M_HEADER  = 3'd1,
    M_DEVADDR = 3'd2,
    M_COMMAND = 3'd3,
    M_ADDRESS = 3'd4,
    M_DATA    = 3'd5,
    M_IDLE    = 3'd6
  } mode_t;

  typedef enum logic [3:0] {
    OP_NONE, OP_READ, OP_WRITE, OP_WREN, OP_WRDI,
    OP_RDSR, OP_WRSR, OP_SETALL, OP_ERASEALL
  } op_t;

  localparam logic [7:0] OPC_READ     = 8'h31;
  localparam logic [7:0] OPC_WRITE    = 8'h32;
  localparam logic [7:0] OPC_WREN     = 8'h41;
  localparam logic [7:0] OPC_WRDI     = 8'h42;
  localparam logic [7:0] OPC_RDSR     = 8'h51;
  localparam logic [7:0] OPC_WRSR     = 8'h52;
  localparam logic [7:0] OPC_SETALL   = 8'h61;
  localparam logic [7:0] OPC_ERASEALL = 8'h62;
endpackage

// File: rtl/swbus_line_watch.sv
module swbus_line_watch #(
  parameter int SBY_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line,
  output logic fall,
  output logic sby_pulse
);
  localparam int CW = $clog2(SBY_CYCLES + 1);
  localparam logic [CW-1:0] CMAX = CW'(SBY_CYCLES);
  localparam logic [CW-1:0] CHIT = CW'(SBY_CYCLES - 1);

  logic [CW-1:0] high_cnt;
  logic          line_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      high_cnt <= '0;
      line_q   <= 1'b1;
    end else begin
      line_q <= line;
      if (!line)                high_cnt <= '0;
      else if (high_cnt != CMAX) high_cnt <= high_cnt + 1'b1;
    end
  end

  // fires once, on the clock where the high run reaches SBY_CYCLES
  assign sby_pulse = line && (high_cnt == CHIT);
  assign fall      = line_q && !line;
endmodule

// File: rtl/swbus_op_decode.sv
module swbus_op_decode
  import swbus_pkg::*;
(
  input  logic [7:0] code,
  output op_t        op
);
  always_comb begin
    unique case (code)
      OPC_READ:     op = OP_READ;
      OPC_WRITE:    op = OP_WRITE;
      OPC_WREN:     op = OP_WREN;
      OPC_WRDI:     op = OP_WRDI;
      OPC_RDSR:     op = OP_RDSR;
      OPC_WRSR:     op = OP_WRSR;
      OPC_SETALL:   op = OP_SETALL;
      OPC_ERASEALL: op = OP_ERASEALL;
      default:      op = OP_NONE;
    endcase
  end
endmodule

// File: rtl/swbus_slave_ctrl.sv
module swbus_slave_ctrl
  import swbus_pkg::*;
#(
  parameter int         SBY_CYCLES = 16,
  parameter logic [7:0] HDR_BYTE   = 8'h55,
  parameter logic [7:0] DEV_ADDR   = 8'hA0,
  parameter int         AW         = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_line,
  input  logic          byte_valid,
  input  logic [7:0]    byte_data,
  input  logic          mak_stb,
  input  logic          nomak_stb,
  input  logic          edge_missed,
  input  logic          wr_busy,
  output logic [2:0]    mode,
  output logic          sak_en,
  output logic          wr_start,
  output logic [AW-1:0] mem_addr
);
  mode_t         mode_q;
  op_t           op_in, op_q;
  logic          ack_wait, wel, wr_q;
  logic [AW-1:0] addr_q;
  logic          line_fall, sby_pulse;

  swbus_line_watch #(.SBY_CYCLES(SBY_CYCLES)) u_watch (
    .clk(clk), .rst_n(rst_n), .line(bus_line),
    .fall(line_fall), .sby_pulse(sby_pulse)
  );

  swbus_op_decode u_dec (.code(byte_data), .op(op_in));

  logic active, live, take_byte, take_ack, blocked, do_write;
  assign active    = (mode_q != M_STANDBY) && (mode_q != M_IDLE);
  assign live      = active && !sby_pulse && !edge_missed;
  assign take_byte = live && byte_valid && !ack_wait;
  assign take_ack  = live && ack_wait && (mak_stb || nomak_stb);
  assign blocked   = (op_in == OP_NONE) ||
                     (wr_busy && (op_in inside {OP_READ, OP_WRITE, OP_WRSR,
                                                OP_SETALL, OP_ERASEALL}));
  assign do_write  = take_ack && nomak_stb && wel && !wr_busy &&
                     (((mode_q == M_COMMAND) && (op_q inside {OP_SETALL, OP_ERASEALL})) ||
                      ((mode_q == M_DATA)    && (op_q inside {OP_WRITE, OP_WRSR})));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= M_STANDBY;
      op_q     <= OP_NONE;
      ack_wait <= 1'b0;
      wel      <= 1'b0;
      wr_q     <= 1'b0;
      addr_q   <= '0;
    end else begin
      wr_q <= do_write;
      if (sby_pulse) begin
        mode_q   <= M_STANDBY;
        ack_wait <= 1'b0;
      end else if (edge_missed && active) begin
        mode_q   <= M_IDLE;
        ack_wait <= 1'b0;
      end else if (mode_q == M_STANDBY) begin
        if (line_fall) mode_q <= M_HEADER;
      end else if (take_byte) begin
        unique case (mode_q)
          M_HEADER:  if (byte_data == HDR_BYTE) ack_wait <= 1'b1;
                     else                       mode_q   <= M_IDLE;
          M_DEVADDR: if (byte_data == DEV_ADDR) ack_wait <= 1'b1;
                     else                       mode_q   <= M_IDLE;
          M_COMMAND: if (blocked) mode_q <= M_IDLE;
                     else begin
                       op_q     <= op_in;
                       ack_wait <= 1'b1;
                     end
          M_ADDRESS: begin
                       addr_q   <= byte_data[AW-1:0];
                       ack_wait <= 1'b1;
                     end
          M_DATA:    begin
                       ack_wait <= 1'b1;
                       if (op_q == OP_READ) addr_q <= addr_q + 1'b1;
                     end
          default:   ;
        endcase
      end else if (take_ack) begin
        ack_wait <= 1'b0;
        if (nomak_stb) begin
          if (mode_q == M_HEADER) mode_q <= M_DEVADDR;
          else                    mode_q <= M_STANDBY;
          if (mode_q == M_COMMAND && op_q == OP_WREN) wel <= 1'b1;
          if (mode_q == M_COMMAND && op_q == OP_WRDI) wel <= 1'b0;
          if (do_write)                               wel <= 1'b0;
        end else begin
          unique case (mode_q)
            M_HEADER:  mode_q <= M_IDLE;
            M_DEVADDR: mode_q <= M_COMMAND;
            M_COMMAND: begin
                         if (op_q inside {OP_READ, OP_WRITE})     mode_q <= M_ADDRESS;
                         else if (op_q inside {OP_RDSR, OP_WRSR}) mode_q <= M_DATA;
                         else                                     mode_q <= M_IDLE;
                       end
            M_ADDRESS: mode_q <= M_DATA;
            M_DATA:    if (op_q == OP_WRSR) mode_q <= M_IDLE;
            default:   ;
          endcase
        end
      end
    end
  end

  assign mode     = mode_q;
  assign sak_en   = ack_wait && (mode_q != M_HEADER);
  assign wr_start = wr_q;
  assign mem_addr = addr_q;
endmodule

// File: rtl/swbus_slave_ctrl_chk.sv
module swbus_slave_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] mode,
  input logic       sak_en,
  input logic       wr_start,
  input logic       nomak_stb,
  input logic       edge_missed,
  input logic       wr_busy,
  input logic       sby_pulse,
  input logic       line_fall
);
  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |=> (mode == 3'd0 && !wr_start) || !rst_n);

  assert_wake_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 3'd0 && line_fall && !sby_pulse |=> mode == 3'd1);

  assert_sby_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sby_pulse |=> mode == 3'd0);

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 3'd6 && !sby_pulse |=> mode == 3'd6);

  assert_header_no_sak_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 3'd1 |-> !sak_en);

  assert_missed_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    edge_missed && !sby_pulse && mode >= 3'd1 && mode <= 3'd5 |=> mode == 3'd6);

  assert_write_in_standby_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |-> mode == 3'd0);

  assert_no_write_when_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    nomak_stb && wr_busy |=> !wr_start);

  assert_write_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |=> !wr_start);
endmodule

bind swbus_slave_ctrl swbus_slave_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .sak_en(sak_en), .wr_start(wr_start),
  .nomak_stb(nomak_stb), .edge_missed(edge_missed), .wr_busy(wr_busy),
  .sby_pulse(sby_pulse), .line_fall(line_fall)
);

// File: tb/swbus_slave_ctrl_test.sv
`timescale 1ns/1ps
module swbus_slave_ctrl_test;
  localparam int         SBY = 16;
  localparam logic [7:0] HDR = 8'h55, DEV = 8'hA0;
  localparam logic [7:0] C_READ = 8'h31, C_WRITE = 8'h32, C_WREN = 8'h41, C_WRDI = 8'h42;
  localparam logic [7:0] C_RDSR = 8'h51, C_WRSR = 8'h52, C_SETALL = 8'h61, C_ERASE = 8'h62;

  logic clk = 1'b0, rst_n = 1'b0, bus_line = 1'b1, byte_valid = 1'b0;
  logic [7:0] byte_data = '0;
  logic mak_stb = 1'b0, nomak_stb = 1'b0, edge_missed = 1'b0, wr_busy = 1'b0;
  logic [2:0] mode;
  logic sak_en, wr_start;
  logic [7:0] mem_addr;
  int checks = 0, fails = 0;
  logic m_wel = 1'b0;

  always #2 clk = ~clk;

  swbus_slave_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_line(bus_line), .byte_valid(byte_valid),
    .byte_data(byte_data), .mak_stb(mak_stb), .nomak_stb(nomak_stb),
    .edge_missed(edge_missed), .wr_busy(wr_busy), .mode(mode), .sak_en(sak_en),
    .wr_start(wr_start), .mem_addr(mem_addr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sby();
    bus_line = 1'b1; cyc(SBY + 2);
  endtask

  task automatic wake();
    bus_line = 1'b0; cyc(1);
  endtask

  task automatic put(input logic [7:0] b);
    byte_data = b; byte_valid = 1'b1; cyc(1); byte_valid = 1'b0;
  endtask

  task automatic ack(input logic mak, output logic w);
    if (mak) mak_stb = 1'b1; else nomak_stb = 1'b1;
    cyc(1);
    w = wr_start;
    mak_stb = 1'b0; nomak_stb = 1'b0;
  endtask

  task automatic open_cmd();
    logic w;
    sby(); wake(); put(HDR); ack(1'b0, w); put(DEV); ack(1'b1, w);
  endtask

  function automatic logic is_blocked(input logic [7:0] op, input logic busy);
    logic known = op inside {C_READ, C_WRITE, C_WREN, C_WRDI, C_RDSR, C_WRSR, C_SETALL, C_ERASE};
    return !known || (busy && (op inside {C_READ, C_WRITE, C_WRSR, C_SETALL, C_ERASE}));
  endfunction

  function automatic logic [2:0] after_cmd_ack(input logic [7:0] op, input logic mak);
    if (!mak) return 3'd0;
    if (op == C_READ || op == C_WRITE) return 3'd4;
    if (op == C_RDSR || op == C_WRSR) return 3'd5;
    return 3'd6;
  endfunction

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic w;
    logic [7:0] ops [9];
    void'($urandom(32'h1234_abcd));
    ops = '{C_READ, C_WRITE, C_WREN, C_WRDI, C_RDSR, C_WRSR, C_SETALL, C_ERASE, 8'h77};
    cyc(3);
    chk("R1 mode", mode, 3'd0); chk("R1 sak_en", sak_en, 0); chk("R1 wr_start", wr_start, 0);
    rst_n = 1'b1; cyc(2);

    sby(); wake(); chk("R2 wake to header", mode, 3'd1);
    put(HDR); chk("R5 no sak in header", sak_en, 0);
    ack(1'b0, w); chk("R5 header nomak", mode, 3'd2);
    put(8'hA1); chk("R6 bad address", mode, 3'd6);
    put(DEV); ack(1'b1, w); ack(1'b0, w); edge_missed = 1'b1; cyc(1); edge_missed = 1'b0;
    bus_line = 1'b1; cyc(3); bus_line = 1'b0; cyc(1);
    chk("R4 idle ignores traffic", mode, 3'd6);
    sby(); chk("R3 standby pulse from idle", mode, 3'd0);

    sby(); wake(); put(8'h54); chk("R5 bad header", mode, 3'd6);
    sby(); wake(); put(HDR); ack(1'b1, w); chk("R5 mak on header", mode, 3'd6);

    sby(); wake(); put(HDR); ack(1'b0, w); put(DEV);
    chk("R6 sak on match", sak_en, 1);
    ack(1'b1, w); chk("R6 to command", mode, 3'd3);
    put(8'h00); chk("R8 unknown opcode", mode, 3'd6);

    open_cmd(); edge_missed = 1'b1; cyc(1); edge_missed = 1'b0;
    chk("R7 missed edge", mode, 3'd6);

    open_cmd(); put(C_WREN); ack(1'b0, w); m_wel = 1'b1;
    chk("R10 wren nomak standby", mode, 3'd0); chk("R11 no write on wren", w, 0);
    open_cmd(); put(C_SETALL); ack(1'b0, w); m_wel = 1'b0;
    chk("R11 setall write", w, 1); chk("R11 setall standby", mode, 3'd0);
    cyc(1); chk("R11 single pulse", wr_start, 0);
    open_cmd(); put(C_ERASE); ack(1'b0, w); chk("R11 latch cleared", w, 0);
    open_cmd(); put(C_WREN); ack(1'b1, w); chk("R9 mak after wren", mode, 3'd6);

    open_cmd(); put(C_READ); ack(1'b1, w); chk("R12 read to address", mode, 3'd4);
    put(8'hFE); ack(1'b1, w); chk("R12 to data", mode, 3'd5); chk("R12 addr load", mem_addr, 8'hFE);
    put(8'h00); chk("R12 addr inc", mem_addr, 8'hFF);
    ack(1'b1, w); chk("R12 mak stays data", mode, 3'd5);
    put(8'h00); chk("R12 addr wrap", mem_addr, 8'h00);
    ack(1'b1, w); put(8'h00); sby(); chk("R3 pulse during data", mode, 3'd0);

    open_cmd(); put(C_WREN); ack(1'b0, w); m_wel = 1'b1;
    open_cmd(); put(C_WRITE); ack(1'b1, w); put(8'h10); ack(1'b1, w); put(8'h5A);
    wr_busy = 1'b1; ack(1'b0, w); wr_busy = 1'b0;
    chk("R11 busy blocks write", w, 0); chk("R10 write end standby", mode, 3'd0);
    open_cmd(); put(C_WRSR); ack(1'b1, w); put(8'h0C); ack(1'b1, w);
    chk("R9 mak after wrsr data", mode, 3'd6);
    open_cmd(); wr_busy = 1'b1; put(C_READ); chk("R8 read while busy", mode, 3'd6);
    open_cmd(); put(C_RDSR); chk("R8 rdsr while busy ok", sak_en, 1);
    ack(1'b0, w); wr_busy = 1'b0;
    open_cmd(); put(C_WRITE); ack(1'b1, w); put(8'h20); ack(1'b1, w); put(8'h33);
    ack(1'b0, w); m_wel = 1'b0; chk("R11 write data start", w, 1);

    for (int i = 0; i < 80; i++) begin
      logic [7:0] op = ops[$urandom_range(0, 8)];
      logic busy = ($urandom_range(0, 3) == 0);
      logic mak = $urandom_range(0, 1);
      logic ew;
      open_cmd(); wr_busy = busy; put(op);
      if (is_blocked(op, busy)) begin
        chk("R8 random blocked", mode, 3'd6);
      end else begin
        chk("R6 random sak", sak_en, 1);
        ack(mak, w);
        ew = !mak && (op == C_SETALL || op == C_ERASE) && m_wel && !busy;
        chk("R11 random write", w, ew);
        chk("R9 random mode", mode, after_cmd_ack(op, mak));
        if (!mak && op == C_WREN) m_wel = 1'b1;
        if (!mak && op == C_WRDI) m_wel = 1'b0;
        if (ew) m_wel = 1'b0;
        if (mak && op == C_WRSR) begin
          mak = $urandom_range(0, 1);
          put(8'h0F); ack(mak, w);
          ew = !mak && m_wel && !busy;
          chk("R11 random wrsr write", w, ew);
          chk("R10 random wrsr end", mode, mak ? 3'd6 : 3'd0);
          if (ew) m_wel = 1'b0;
        end
      end
      wr_busy = 1'b0;
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule